// File: doc/BRIEF.md
# Copy-Engine Channel Register File

This block is the software-visible register file for a multi-channel memory copy engine. A device-relative byte address is split into a window number and an offset within that window. Each window is 0x80 bytes. Window 0 holds device-wide registers that live elsewhere, and window *n* (n ≥ 1) belongs to channel *n*−1. Per channel it keeps a control word, a status word, two 64-bit pointers (the descriptor-chain start and the completion-record target), a command byte and an error word.

Requests arrive on a plain one-cycle port carrying valid, write, address, size in bytes and write data. Every request gets a response one cycle later, with read data and an error flag. A command write becomes a one-cycle start, append or reset pulse toward that channel's sequencer. The sequencer sends back a busy level, status loads, error bits and interrupt-disable set requests. The pointers and the control word are presented on flat output buses for the sequencer to use.

Top module: `dma_chan_regs`

## Requirements
- R1: A request with `req_valid` high gets a response one cycle later, with `rsp_valid` high for exactly one cycle. Channel index = (address / 0x80) − 1 and register offset = address mod 0x80.
- R2: An access to window 0 (address below 0x80), to a channel index at or above `NCHAN`, or to an offset not listed below returns `rsp_err`=1 and read data 0, and changes no register.
- R3: `req_size` is the byte count. Any size other than the one allowed for the addressed register, including sizes outside {1,2,4,8}, returns `rsp_err`=1 and changes nothing.
- R4: Control is 16 bits at offset 0x00, size 2. A write loads bits 15:1. Bit 0 (interrupt disable) goes to 0 when the written bit 0 is 1 and is otherwise kept. `intdis_set` sets bit 0 after any write in the same cycle.
- R5: Status is 64 bits at offset 0x08, size 8. A read returns the stored value with bit 0 forced to 1 while `chan_busy` is low. A size-8 write is accepted and has no effect.
- R6: `status_we` loads the stored status from `status_in`.
- R7: Chain address: offset 0x10 at size 8 covers all 64 bits, and at size 4 covers bits 31:0. Offset 0x14 at size 4 covers bits 63:32. A half access leaves the other half intact, and a 4-byte read returns that half in bits 31:0.
- R8: Completion address has the same layout at offsets 0x20 and 0x24.
- R9: Command is offset 0x18, size 1. Written bit 0 (start), bit 1 (append) and bit 2 (reset) each give a one-cycle pulse on `cmd_start`, `cmd_append` and `cmd_reset` for that channel, in the response cycle. The register self-clears, so reads return 0.
- R10: Error is 32 bits at offset 0x28, size 4. A write clears the bits written as 1, and `err_set` bits are then ORed in.
- R11: After reset, status is 3 (transfer-status field, bits 2:0, holds 3), and control, both pointers, error and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Device-relative byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Read data, right-aligned |
| cmd_start | output | NCHAN | Start pulse per channel |
| cmd_append | output | NCHAN | Append pulse per channel |
| cmd_reset | output | NCHAN | Reset pulse per channel |
| ctrl_out | output | NCHAN*16 | Control words, channel c at [c*16+:16] |
| chain_addr | output | NCHAN*64 | Descriptor-chain addresses |
| compl_addr | output | NCHAN*64 | Completion addresses |
| chan_busy | input | NCHAN | Channel busy from the sequencer |
| status_we | input | NCHAN | Status load strobe |
| status_in | input | NCHAN*64 | Status load values |
| err_set | input | NCHAN*32 | Error bits to set |
| intdis_set | input | NCHAN | Set interrupt-disable bit |

## Verification
The bench builds the block with `NCHAN`=3 and `ADDR_W`=10. This gives eight windows: window 0, three real channels and four unpopulated ones, so the global-window rejection and the out-of-range rejection are both reached by ordinary stimulus. Three channels also let the bench check that pulses, half-pointer updates and error clears land on the addressed channel only. Sequencer-side strobes are driven at random alongside bus traffic, which covers same-cycle write/set collisions on the control and error words.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCHAN  = 4,
  parameter int ADDR_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_size,
  input  logic [63:0]         req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [63:0]         rsp_rdata,
  output logic [NCHAN-1:0]    cmd_start,
  output logic [NCHAN-1:0]    cmd_append,
  output logic [NCHAN-1:0]    cmd_reset,
  output logic [NCHAN*16-1:0] ctrl_out,
  output logic [NCHAN*64-1:0] chain_addr,
  output logic [NCHAN*64-1:0] compl_addr,
  input  logic [NCHAN-1:0]    chan_busy,
  input  logic [NCHAN-1:0]    status_we,
  input  logic [NCHAN*64-1:0] status_in,
  input  logic [NCHAN*32-1:0] err_set,
  input  logic [NCHAN-1:0]    intdis_set
);
  localparam int IDX_W = ADDR_W - 7;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCHAN);
  localparam logic [6:0] OFS_CTRL = 7'h00, OFS_STAT = 7'h08, OFS_CHL = 7'h10,
                         OFS_CHH = 7'h14, OFS_CMD = 7'h18, OFS_CPL = 7'h20,
                         OFS_CPH = 7'h24, OFS_ERR = 7'h28;

  logic [15:0] ctrl_q  [NCHAN];
  logic [63:0] stat_q  [NCHAN];
  logic [63:0] chain_q [NCHAN];
  logic [63:0] compl_q [NCHAN];
  logic [31:0] err_q   [NCHAN];

  logic [IDX_W-1:0] idx, sel;
  logic [6:0]       off;
  logic             in_range, size_ok, acc_ok, wr;
  logic [63:0]      rd;

  assign idx      = req_addr[ADDR_W-1:7];
  assign off      = req_addr[6:0];
  assign sel      = idx - 1'b1;
  assign in_range = (idx != '0) && (idx <= LAST_IDX);
  assign acc_ok   = in_range && size_ok;
  assign wr       = req_valid && req_write && acc_ok;

  always_comb begin
    case (off)
      OFS_CTRL:                  size_ok = req_size == 4'd2;
      OFS_STAT:                  size_ok = req_size == 4'd8;
      OFS_CHL, OFS_CPL:          size_ok = req_size == 4'd8 || req_size == 4'd4;
      OFS_CHH, OFS_CPH, OFS_ERR: size_ok = req_size == 4'd4;
      OFS_CMD:                   size_ok = req_size == 4'd1;
      default:                   size_ok = 1'b0;
    endcase
  end

  always_comb begin
    rd = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (sel == IDX_W'(c)) begin
        case (off)
          OFS_CTRL: rd = {48'd0, ctrl_q[c]};
          OFS_STAT: rd = stat_q[c] | {63'd0, ~chan_busy[c]};
          OFS_CHL:  rd = (req_size == 4'd8) ? chain_q[c] : {32'd0, chain_q[c][31:0]};
          OFS_CHH:  rd = {32'd0, chain_q[c][63:32]};
          OFS_CPL:  rd = (req_size == 4'd8) ? compl_q[c] : {32'd0, compl_q[c][31:0]};
          OFS_CPH:  rd = {32'd0, compl_q[c][63:32]};
          OFS_ERR:  rd = {32'd0, err_q[c]};
          default:  rd = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd : '0;
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    logic hit;
    assign hit = wr && (sel == IDX_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[c]     <= '0;
        stat_q[c]     <= 64'd3;
        chain_q[c]    <= '0;
        compl_q[c]    <= '0;
        err_q[c]      <= '0;
        cmd_start[c]  <= 1'b0;
        cmd_append[c] <= 1'b0;
        cmd_reset[c]  <= 1'b0;
      end else begin
        if (hit && off == OFS_CTRL)
          ctrl_q[c] <= {req_wdata[15:1], (!req_wdata[0] && ctrl_q[c][0]) || intdis_set[c]};
        else if (intdis_set[c])
          ctrl_q[c][0] <= 1'b1;

        if (status_we[c])
          stat_q[c] <= status_in[c*64 +: 64];

        if (hit && off == OFS_CHL && req_size == 4'd8) chain_q[c]        <= req_wdata;
        if (hit && off == OFS_CHL && req_size == 4'd4) chain_q[c][31:0]  <= req_wdata[31:0];
        if (hit && off == OFS_CHH)                     chain_q[c][63:32] <= req_wdata[31:0];

        if (hit && off == OFS_CPL && req_size == 4'd8) compl_q[c]        <= req_wdata;
        if (hit && off == OFS_CPL && req_size == 4'd4) compl_q[c][31:0]  <= req_wdata[31:0];
        if (hit && off == OFS_CPH)                     compl_q[c][63:32] <= req_wdata[31:0];

        err_q[c] <= (err_q[c] & ~((hit && off == OFS_ERR) ? req_wdata[31:0] : 32'd0))
                  | err_set[c*32 +: 32];

        cmd_start[c]  <= hit && off == OFS_CMD && req_wdata[0];
        cmd_append[c] <= hit && off == OFS_CMD && req_wdata[1];
        cmd_reset[c]  <= hit && off == OFS_CMD && req_wdata[2];
      end
    end

    assign ctrl_out[c*16 +: 16]   = ctrl_q[c];
    assign chain_addr[c*64 +: 64] = chain_q[c];
    assign compl_addr[c*64 +: 64] = compl_q[c];
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCHAN = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic [63:0]         rsp_rdata,
  input logic [NCHAN-1:0]    cmd_start,
  input logic [NCHAN-1:0]    cmd_append,
  input logic [NCHAN-1:0]    cmd_reset,
  input logic [NCHAN*16-1:0] ctrl_out,
  input logic [NCHAN*64-1:0] chain_addr,
  input logic [NCHAN*64-1:0] compl_addr,
  input logic [NCHAN-1:0]    intdis_set
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_err_zero_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 64'd0 && rsp_valid));
  assert_one_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_start) && $onehot0(cmd_append) && $onehot0(cmd_reset));
  assert_pulse_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{cmd_start, cmd_append, cmd_reset}) |-> $past(req_valid && req_write));
  assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{cmd_start, cmd_append, cmd_reset}) |=> !(|{cmd_start, cmd_append, cmd_reset}) || $past(req_valid && req_write));
  assert_chain_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chain_addr) |-> $past(req_valid && req_write));
  assert_compl_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(compl_addr) |-> $past(req_valid && req_write));

  for (genvar c = 0; c < NCHAN; c++) begin : g_ctl
    assert_intdis_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_out[c*16]) |-> $past(intdis_set[c]));
    assert_intdis_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_out[c*16]) |-> $past(req_valid && req_write));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .cmd_start(cmd_start), .cmd_append(cmd_append), .cmd_reset(cmd_reset),
  .ctrl_out(ctrl_out), .chain_addr(chain_addr), .compl_addr(compl_addr),
  .intdis_set(intdis_set)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  localparam int NC = 3;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [NC-1:0] cmd_start, cmd_append, cmd_reset;
  logic [NC*16-1:0] ctrl_out;
  logic [NC*64-1:0] chain_addr, compl_addr;
  logic [NC-1:0] chan_busy = '0, status_we = '0, intdis_set = '0;
  logic [NC*64-1:0] status_in = '0;
  logic [NC*32-1:0] err_set = '0;

  always #10 clk = ~clk;

  dma_chan_regs #(.NCHAN(NC), .ADDR_W(AW)) i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_start(cmd_start), .cmd_append(cmd_append), .cmd_reset(cmd_reset),
    .ctrl_out(ctrl_out), .chain_addr(chain_addr), .compl_addr(compl_addr),
    .chan_busy(chan_busy), .status_we(status_we), .status_in(status_in),
    .err_set(err_set), .intdis_set(intdis_set));

  // reference model state
  logic [15:0] m_ctrl [NC];
  logic [63:0] m_stat [NC], m_chain [NC], m_compl [NC];
  logic [31:0] m_err [NC];
  logic e_valid, e_err;
  logic [63:0] e_rdata;
  logic [NC-1:0] e_st, e_ap, e_rs;
  string e_tag = "R11";
  bit started = 0, done = 0;
  int vectors = 0, miscompares = 0;

  // legal sizes per offset as a bitmask indexed by byte count
  function automatic int legal_sizes(int o);
    if (o == 'h00) return 1 << 2;
    if (o == 'h08) return 1 << 8;
    if (o == 'h10 || o == 'h20) return (1 << 8) | (1 << 4);
    if (o == 'h14 || o == 'h24 || o == 'h28) return 1 << 4;
    if (o == 'h18) return 1 << 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_ctrl[c] = 0; m_stat[c] = 3; m_chain[c] = 0; m_compl[c] = 0; m_err[c] = 0;
      end
      e_valid = 0; e_err = 0; e_rdata = 0; e_st = 0; e_ap = 0; e_rs = 0; e_tag = "R11";
    end else begin
      int win, ch, o, sz, mask;
      bit ok;
      logic [31:0] wl;
      win = int'(req_addr) / 128; ch = win - 1; o = int'(req_addr) % 128; sz = int'(req_size);
      mask = legal_sizes(o);
      ok = (win >= 1) && (win <= NC) && (sz <= 8) && mask[sz];
      wl = req_wdata[31:0];
      e_valid = req_valid; e_err = req_valid && !ok; e_rdata = 0;
      e_st = 0; e_ap = 0; e_rs = 0;
      e_tag = "R1";
      if (req_valid && !ok)
        e_tag = (win < 1 || win > NC || mask == 0) ? "R2" : "R3";
      if (req_valid && ok) begin
        case (o)
          'h00: e_tag = "R4";
          'h08: e_tag = "R5 R6";
          'h10, 'h14: e_tag = "R7";
          'h20, 'h24: e_tag = "R8";
          'h18: e_tag = "R9";
          default: e_tag = "R10";
        endcase
        if (!req_write) begin
          if (o == 'h00) e_rdata = {48'd0, m_ctrl[ch]};
          if (o == 'h08) e_rdata = chan_busy[ch] ? m_stat[ch] : (m_stat[ch] | 64'd1);
          if (o == 'h10) e_rdata = (sz == 8) ? m_chain[ch] : {32'd0, m_chain[ch][31:0]};
          if (o == 'h14) e_rdata = {32'd0, m_chain[ch][63:32]};
          if (o == 'h20) e_rdata = (sz == 8) ? m_compl[ch] : {32'd0, m_compl[ch][31:0]};
          if (o == 'h24) e_rdata = {32'd0, m_compl[ch][63:32]};
          if (o == 'h28) e_rdata = {32'd0, m_err[ch]};
        end else begin
          if (o == 'h00) begin
            logic keep;
            keep = m_ctrl[ch][0];
            m_ctrl[ch] = req_wdata[15:0];
            m_ctrl[ch][0] = req_wdata[0] ? 1'b0 : keep;
          end
          if (o == 'h10 && sz == 8) m_chain[ch] = req_wdata;
          if (o == 'h10 && sz == 4) m_chain[ch] = {m_chain[ch][63:32], wl};
          if (o == 'h14) m_chain[ch] = {wl, m_chain[ch][31:0]};
          if (o == 'h20 && sz == 8) m_compl[ch] = req_wdata;
          if (o == 'h20 && sz == 4) m_compl[ch] = {m_compl[ch][63:32], wl};
          if (o == 'h24) m_compl[ch] = {wl, m_compl[ch][31:0]};
          if (o == 'h28) m_err[ch] = m_err[ch] & ~wl;
          if (o == 'h18) begin
            e_st[ch] = req_wdata[0]; e_ap[ch] = req_wdata[1]; e_rs[ch] = req_wdata[2];
          end
        end
      end
      for (int c = 0; c < NC; c++) begin
        if (status_we[c]) m_stat[c] = status_in[c*64 +: 64];
        if (intdis_set[c]) m_ctrl[c][0] = 1'b1;
        m_err[c] = m_err[c] | err_set[c*32 +: 32];
      end
    end
  end

  task automatic chk(string tag, string what, logic [191:0] got, logic [191:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (started && !done) begin
      logic [NC*16-1:0] ec;
      logic [NC*64-1:0] eh, ep;
      vectors++;
      for (int c = 0; c < NC; c++) begin
        ec[c*16 +: 16] = m_ctrl[c]; eh[c*64 +: 64] = m_chain[c]; ep[c*64 +: 64] = m_compl[c];
      end
      chk(rst_n ? "R1" : "R11", "rsp_valid", 192'(rsp_valid), 192'(e_valid));
      chk(e_tag, "rsp_err", 192'(rsp_err), 192'(e_err));
      chk(e_tag, "rsp_rdata", 192'(rsp_rdata), 192'(e_rdata));
      chk(rst_n ? "R9" : "R11", "cmd pulses", 192'({cmd_start, cmd_append, cmd_reset}), 192'({e_st, e_ap, e_rs}));
      chk(rst_n ? "R4" : "R11", "ctrl_out", 192'(ctrl_out), 192'(ec));
      chk(rst_n ? "R7" : "R11", "chain_addr", 192'(chain_addr), 192'(eh));
      chk(rst_n ? "R8" : "R11", "compl_addr", 192'(compl_addr), 192'(ep));
    end
  end

  task automatic acc(bit w, int addr, int sz, logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(addr); req_size = 4'(sz); req_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_write = 0; status_we = 0; intdis_set = 0; err_set = 0;
    end
  endtask

  function automatic int base(int c);
    return (c + 1) * 128;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog: got hang expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset values read back
    acc(0, base(0) + 'h08, 8, 0);
    acc(0, base(1) + 'h20, 8, 0);
    acc(0, base(2) + 'h28, 4, 0);
    // R4 control and sticky interrupt-disable
    acc(1, base(0) + 'h00, 2, 64'hABCD);
    acc(0, base(0) + 'h00, 2, 0);
    idle(1);
    @(negedge clk); intdis_set = 3'b010;
    @(negedge clk); intdis_set = 0;
    acc(0, base(1) + 'h00, 2, 0);
    acc(1, base(1) + 'h00, 2, 64'h0002);
    acc(0, base(1) + 'h00, 2, 0);
    acc(1, base(1) + 'h00, 2, 64'h0001);
    acc(0, base(1) + 'h00, 2, 0);
    // R7 chain halves
    acc(1, base(2) + 'h10, 8, 64'h1122334455667788);
    acc(1, base(2) + 'h10, 4, 64'hFFFF0000DEADBEEF);
    acc(0, base(2) + 'h10, 8, 0);
    acc(1, base(2) + 'h14, 4, 64'h00000000CAFEF00D);
    acc(0, base(2) + 'h10, 4, 0);
    acc(0, base(2) + 'h14, 4, 0);
    // R8 completion halves
    acc(1, base(0) + 'h24, 4, 64'h0000000012345678);
    acc(1, base(0) + 'h20, 4, 64'h000000009ABCDEF0);
    acc(0, base(0) + 'h20, 8, 0);
    // R5 R6 status with busy and loads
    idle(1);
    @(negedge clk); chan_busy = 3'b001; status_we = 3'b001; status_in[63:0] = 64'h00000000000000F0;
    @(negedge clk); status_we = 0;
    acc(0, base(0) + 'h08, 8, 0);
    idle(1); chan_busy = 0;
    acc(0, base(0) + 'h08, 8, 0);
    acc(1, base(0) + 'h08, 8, 64'hFFFF);
    acc(0, base(0) + 'h08, 8, 0);
    acc(0, base(0) + 'h08, 4, 0);
    // R9 command strobes
    acc(1, base(1) + 'h18, 1, 64'h07);
    acc(1, base(2) + 'h18, 1, 64'h01);
    acc(0, base(2) + 'h18, 1, 0);
    acc(1, base(0) + 'h18, 2, 64'h07);
    idle(2);
    // R10 error write-one-to-clear
    @(negedge clk); err_set[31:0] = 32'hF0F0000F;
    @(negedge clk); err_set = 0;
    acc(0, base(0) + 'h28, 4, 0);
    acc(1, base(0) + 'h28, 4, 64'h3);
    acc(0, base(0) + 'h28, 4, 0);
    // R2 R3 rejected accesses
    acc(1, 'h10, 8, 64'h55);
    acc(0, 'h10, 8, 0);
    acc(1, base(3) + 'h10, 8, 64'h77);
    acc(0, base(5) + 'h00, 2, 0);
    acc(1, base(0) + 'h30, 4, 64'h1);
    acc(1, base(0) + 'h11, 4, 64'h1);
    acc(1, base(0) + 'h10, 3, 64'h1);
    acc(1, base(0) + 'h10, 2, 64'h1);
    acc(0, base(0) + 'h00, 0, 0);
    acc(0, base(2) + 'h14, 8, 0);
    acc(0, base(0) + 'h10, 8, 0);
    idle(1);
    // mixed traffic with sequencer strobes
    for (int i = 0; i < 3000; i++) begin
      int offs [10] = '{'h00, 'h08, 'h10, 'h14, 'h18, 'h20, 'h24, 'h28, 'h30, 'h0c};
      int szs [6] = '{1, 2, 4, 8, 3, 0};
      @(negedge clk);
      req_valid = ($urandom % 4) != 0;
      req_write = $urandom % 2;
      req_addr = AW'(($urandom % 6) * 128 + offs[$urandom % 10]);
      req_size = 4'(szs[$urandom % 6]);
      req_wdata = {$urandom, $urandom};
      chan_busy = NC'($urandom);
      status_we = NC'($urandom & $urandom & $urandom);
      status_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      intdis_set = NC'($urandom & $urandom & $urandom);
      err_set = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
    end
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule